// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block manages thirteen general-purpose pins through a byte-wide register bus. Every pin owns two configuration bytes. The drive byte chooses the direction and the driver style, either push-pull or open-drain. It also chooses an optional pull resistor with two strengths and two polarities, and it holds the value to drive. The sense byte returns the synchronised pin level and selects which transitions on that pin raise an event.

Events collect in two sticky status registers. Pins 0 to 6 sit in the low group and pins 7 to 12 in the high group. Software clears a status bit by writing a one to it. Each group has a mask register. A single interrupt line stays high while any status bit is set whose mask bit is clear. A transition that arrives while software is servicing sets its bit again, so software can read status repeatedly until it finds it empty.

Pad-side outputs give the output enable, the output value and the pull request for each pin. The asynchronous pin inputs pass through a two-stage synchroniser before any logic uses them.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every drive byte and sense selection is 0, all status bits are 0, the mask registers read 0x7F (low group) and 0x3F (high group), `irq` is 0 and no pad is enabled.
- R2: The drive byte of pin n is at 0x4E44+n and reads back bits 5:0 as written, with bits 7:6 reading 0. Addresses outside the mapped set read 0, and writes to them change no register.
- R3: Drive byte fields: bit 5 = output direction, bit 4 = push-pull (0 = open-drain), bit 0 = value. Push-pull output drives `pad_oe`=1 and `pad_out`=value. Open-drain output enables the pad only when the value is 0, with `pad_out`=0. Input direction gives `pad_oe`=0.
- R4: Drive byte bit 3 enables the pull and bits 2:1 select it: 0 = strong down, 1 = strong up, 2 = weak down, 3 = weak up. The outputs `pad_pull_en`, `pad_pull_up` and `pad_pull_strong` reflect this selection, and all three are 0 when the pull is disabled.
- R5: The sense byte of pin n is at 0x4E51+n. Bit 0 returns the pin level after a two-stage synchroniser, and writes to bit 0 are ignored.
- R6: Sense byte bits 2:1 select event detection: 0 = none, 1 = falling, 2 = rising, 3 = both. A matching transition sets the pin's status bit.
- R7: Status of pins 0–6 is at 0x4E0B bits 6:0. Status of pins 7–12 is at 0x4E0C bits 5:0, with pin 7 in bit 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Without a clearing write, a set bit stays set.
- R9: The mask registers are at 0x4E19 (pins 0–6) and 0x4E1A (pins 7–12), laid out like status. A status bit is recorded whatever its mask bit is, and `irq` equals the OR of every status bit whose mask bit is 0.
- R10: When a detected transition and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R11: `bus_rdata` updates on the clock edge where `bus_re` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 13 | Asynchronous pin levels |
| pad_oe | output | 13 | Pad output enable per pin |
| pad_out | output | 13 | Pad output value per pin |
| pad_pull_en | output | 13 | Pull resistor enable per pin |
| pad_pull_up | output | 13 | Pull polarity, 1 = up |
| pad_pull_strong | output | 13 | Pull strength, 1 = strong |
| irq | output | 1 | Interrupt, high while an unmasked event is pending |

## Verification
A register write takes effect on the edge that accepts it, so the pad outputs and `irq` are sampled at the next falling edge. Read data is one edge behind `bus_re`. A new pin level shows in the sense byte two edges after the pin changes, and the matching status bit and `irq` follow on the third edge. The bench therefore drives a pin at a falling edge and waits three falling edges before it compares. The latency test and the test where an event collides with a clear place the read or the write on the exact edge, counted from the pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_mode_e;

  // Drive byte, bit 5 down to bit 0.
  typedef struct packed {
    logic       dir_out;
    logic       push_pull;
    logic       pull_en;
    logic [1:0] pull_sel;
    logic       drive_val;
  } octl_t;

  localparam int OCTL_W = $bits(octl_t);

  function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
    case (mode)
      EDGE_FALL: return prev & ~cur;
      EDGE_RISE: return ~prev & cur;
      EDGE_ANY:  return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_edge_pin.sv
module gpio_edge_pin
  import gpio_edge_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              octl_we,
  input  logic              ictl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pad_in,
  output octl_t             octl_q,
  output edge_mode_e        mode_q,
  output logic              level,
  output logic              edge_hit,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              pull_en,
  output logic              pull_up,
  output logic              pull_strong
);

  octl_t                  octl_d;
  edge_mode_e             mode_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      assign sync_d = pad_in;
    end else begin : g_sync_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pad_in};
    end
  endgenerate

  always_comb begin
    octl_d = octl_q;
    if (octl_we) octl_d = octl_t'(wdata[OCTL_W-1:0]);
    mode_d = mode_q;
    if (ictl_we) mode_d = edge_mode_e'(wdata[2:1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octl_q <= '0;
      mode_q <= EDGE_OFF;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      octl_q <= octl_d;
      mode_q <= mode_d;
      sync_q <= sync_d;
      prev_q <= level;
    end
  end

  assign level    = sync_q[SYNC_STAGES-1];
  assign edge_hit = edge_match(mode_q, prev_q, level);

  assign pad_oe      = octl_q.dir_out & (octl_q.push_pull | ~octl_q.drive_val);
  assign pad_out     = octl_q.push_pull & octl_q.drive_val;
  assign pull_en     = octl_q.pull_en;
  assign pull_up     = octl_q.pull_en & octl_q.pull_sel[0];
  assign pull_strong = octl_q.pull_en & ~octl_q.pull_sel[1];

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NUM_PINS  = 13,
  parameter int GRP0_PINS = 7,
  parameter int DATA_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] edge_hit,
  input  logic [1:0]          stat_we,
  input  logic [1:0]          mask_we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] mask,
  output logic                irq
);

  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      localparam int GRP = (i >= GRP0_PINS) ? 1 : 0;
      localparam int POS = (i >= GRP0_PINS) ? (i - GRP0_PINS) : i;
      logic st_q, st_d, mk_q, mk_d;

      always_comb begin
        st_d = st_q;
        if (stat_we[GRP] && wdata[POS]) st_d = 1'b0;
        if (edge_hit[i])                st_d = 1'b1;
        mk_d = mk_q;
        if (mask_we[GRP])               mk_d = wdata[POS];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q <= 1'b0;
          mk_q <= 1'b1;
        end else begin
          st_q <= st_d;
          mk_q <= mk_d;
        end
      end

      assign status[i] = st_q;
      assign mask[i]   = mk_q;
    end
  endgenerate

  assign irq = |(status & ~mask);

  initial begin
    if (GRP0_PINS > DATA_W || GRP1_PINS > DATA_W || GRP1_PINS < 1)
      $display("gpio_edge_irq: group split does not fit the data width");
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 13,
  parameter int GRP0_PINS   = 7,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OCTL_BASE   = 'h4e44,
  parameter int ICTL_BASE   = 'h4e51,
  parameter int STAT_BASE   = 'h4e0b,
  parameter int MASK_BASE   = 'h4e19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_we,
  input  logic                bus_re,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_pull_en,
  output logic [NUM_PINS-1:0] pad_pull_up,
  output logic [NUM_PINS-1:0] pad_pull_strong,
  output logic                irq
);

  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  octl_t               octl_arr  [NUM_PINS];
  edge_mode_e          mode_arr  [NUM_PINS];
  logic [NUM_PINS-1:0] octl_we, ictl_we, level_vec, edge_hit, dir_vec;
  logic [NUM_PINS-1:0] status, mask;
  logic [1:0]          stat_we, mask_we;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign octl_we[i] = bus_we && (bus_addr == ADDR_W'(OCTL_BASE + i));
      assign ictl_we[i] = bus_we && (bus_addr == ADDR_W'(ICTL_BASE + i));

      gpio_edge_pin #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
      ) pin_i (
        .clk         (clk),
        .rst_n       (rst_core_n),
        .octl_we     (octl_we[i]),
        .ictl_we     (ictl_we[i]),
        .wdata       (bus_wdata),
        .pad_in      (pad_in[i]),
        .octl_q      (octl_arr[i]),
        .mode_q      (mode_arr[i]),
        .level       (level_vec[i]),
        .edge_hit    (edge_hit[i]),
        .pad_oe      (pad_oe[i]),
        .pad_out     (pad_out[i]),
        .pull_en     (pad_pull_en[i]),
        .pull_up     (pad_pull_up[i]),
        .pull_strong (pad_pull_strong[i])
      );

      assign dir_vec[i] = octl_arr[i].dir_out;
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
      assign stat_we[g] = bus_we && (bus_addr == ADDR_W'(STAT_BASE + g));
      assign mask_we[g] = bus_we && (bus_addr == ADDR_W'(MASK_BASE + g));
    end
  endgenerate

  gpio_edge_irq #(
    .NUM_PINS  (NUM_PINS),
    .GRP0_PINS (GRP0_PINS),
    .DATA_W    (DATA_W)
  ) irq_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .edge_hit (edge_hit),
    .stat_we  (stat_we),
    .mask_we  (mask_we),
    .wdata    (bus_wdata),
    .status   (status),
    .mask     (mask),
    .irq      (irq)
  );

  // Registered read path.
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (bus_re) begin
      rdata_d = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
        if (bus_addr == ADDR_W'(OCTL_BASE + i)) rdata_d = DATA_W'(octl_arr[i]);
        if (bus_addr == ADDR_W'(ICTL_BASE + i)) rdata_d = DATA_W'({mode_arr[i], level_vec[i]});
      end
      if (bus_addr == ADDR_W'(STAT_BASE))     rdata_d = DATA_W'(status[GRP0_PINS-1:0]);
      if (bus_addr == ADDR_W'(STAT_BASE + 1)) rdata_d = DATA_W'(status[NUM_PINS-1:GRP0_PINS]);
      if (bus_addr == ADDR_W'(MASK_BASE))     rdata_d = DATA_W'(mask[GRP0_PINS-1:0]);
      if (bus_addr == ADDR_W'(MASK_BASE + 1)) rdata_d = DATA_W'(mask[NUM_PINS-1:GRP0_PINS]);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  initial begin
    if (GRP1_PINS < 1) $display("gpio_edge_ctrl: high group is empty");
  end

endmodule

// File: rtl/gpio_edge_chk.sv
module gpio_edge_chk #(
  parameter int NUM_PINS = 13,
  parameter int DATA_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          stat_we,
  input logic [NUM_PINS-1:0] edge_hit,
  input logic [NUM_PINS-1:0] status,
  input logic [NUM_PINS-1:0] mask,
  input logic [NUM_PINS-1:0] dir_vec,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_pull_en,
  input logic [NUM_PINS-1:0] pad_pull_up,
  input logic [NUM_PINS-1:0] pad_pull_strong,
  input logic                irq,
  input logic                bus_re,
  input logic [DATA_W-1:0]   bus_rdata
);

  p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_vec) == '0);

  p_pull_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_up | pad_pull_strong) & ~pad_pull_en) == '0);

  p_set_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit == '0) |=> ((status & ~$past(status)) == '0));

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we == 2'b00) |=> ((status & $past(status)) == $past(status)));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ~mask) != '0));

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

endmodule

bind gpio_edge_ctrl gpio_edge_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_core_n),
  .stat_we         (stat_we),
  .edge_hit        (edge_hit),
  .status          (status),
  .mask            (mask),
  .dir_vec         (dir_vec),
  .pad_oe          (pad_oe),
  .pad_pull_en     (pad_pull_en),
  .pad_pull_up     (pad_pull_up),
  .pad_pull_strong (pad_pull_strong),
  .irq             (irq),
  .bus_re          (bus_re),
  .bus_rdata       (bus_rdata)
);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb_top;

  localparam int N = 13;
  localparam logic [15:0] A_OCTL = 16'h4e44;
  localparam logic [15:0] A_ICTL = 16'h4e51;
  localparam logic [15:0] A_STAT = 16'h4e0b;
  localparam logic [15:0] A_MASK = 16'h4e19;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_we, bus_re;
  logic [7:0]    bus_rdata;
  logic [N-1:0]  pad_in, pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_pull_strong;
  logic          irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_edge_ctrl dut_i (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata), .pad_in (pad_in),
    .pad_oe (pad_oe), .pad_out (pad_out), .pad_pull_en (pad_pull_en),
    .pad_pull_up (pad_pull_up), .pad_pull_strong (pad_pull_strong), .irq (irq)
  );

  // Bench model
  logic [1:0]   mode_m [N];
  logic [N-1:0] lvl_m, st_m, mk_m;

  function automatic logic hit_m(logic [1:0] mode, logic old_v, logic new_v);
    if (old_v == new_v) return 1'b0;
    if (mode == 2'd3)   return 1'b1;
    if (mode == 2'd2)   return new_v;
    if (mode == 2'd1)   return ~new_v;
    return 1'b0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_re = 1'b0;
  endtask

  // Pin change, then three edges: two synchroniser stages and the status register.
  task automatic set_pad(int p, logic v);
    @(negedge clk);
    pad_in[p] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_status(string req);
    logic [7:0] d0, d1;
    bus_read(A_STAT, d0);
    bus_read(A_STAT + 16'd1, d1);
    chk(req, {24'd0, d0}, {25'd0, st_m[6:0]});
    chk(req, {24'd0, d1}, {26'd0, st_m[12:7]});
    chk(req, {31'd0, irq}, {31'd0, |(st_m & ~mk_m)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] codes [5];
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; pad_in = '0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pad_oe", {19'd0, pad_oe}, 0);
    bus_read(A_OCTL, d);               chk("R1 drive byte", {24'd0, d}, 0);
    bus_read(A_ICTL + 16'd12, d);      chk("R1 sense byte", {24'd0, d}, 0);
    bus_read(A_STAT, d);               chk("R1 status low", {24'd0, d}, 0);
    bus_read(A_STAT + 16'd1, d);       chk("R1 status high", {24'd0, d}, 0);
    bus_read(A_MASK, d);               chk("R1 mask low", {24'd0, d}, 32'h7f);
    bus_read(A_MASK + 16'd1, d);       chk("R1 mask high", {24'd0, d}, 32'h3f);

    // R2 addressing and readback
    bus_write(A_OCTL + 16'd12, 8'hff);
    bus_read(A_OCTL + 16'd12, d);      chk("R2 pin12 drive", {24'd0, d}, 32'h3f);
    bus_write(A_OCTL, 8'h2a);
    bus_read(A_OCTL, d);               chk("R2 pin0 drive", {24'd0, d}, 32'h2a);
    bus_write(16'h4e5e, 8'hff);
    bus_read(16'h4e5e, d);             chk("R2 unmapped high", {24'd0, d}, 0);
    bus_read(16'h4e43, d);             chk("R2 unmapped low", {24'd0, d}, 0);
    bus_read(A_OCTL + 16'd1, d);       chk("R2 neighbour untouched", {24'd0, d}, 0);
    bus_write(A_OCTL + 16'd12, 8'h00);
    bus_write(A_OCTL, 8'h00);

    // R3 drive modes on pin 2
    codes[0] = 8'h31; codes[1] = 8'h30; codes[2] = 8'h21; codes[3] = 8'h20; codes[4] = 8'h11;
    for (int k = 0; k < 5; k++) begin
      logic oe_e, out_e;
      bus_write(A_OCTL + 16'd2, codes[k]);
      oe_e  = codes[k][5] & (codes[k][4] | ~codes[k][0]);
      out_e = codes[k][4] & codes[k][0];
      chk("R3 pad_oe", {31'd0, pad_oe[2]}, {31'd0, oe_e});
      if (oe_e) chk("R3 pad_out", {31'd0, pad_out[2]}, {31'd0, out_e});
    end
    bus_write(A_OCTL + 16'd2, 8'h00);

    // R4 pull selection on pin 5
    for (int s = 0; s < 4; s++) begin
      bus_write(A_OCTL + 16'd5, 8'h08 | 8'(s << 1));
      chk("R4 pull", {29'd0, pad_pull_en[5], pad_pull_up[5], pad_pull_strong[5]},
          {29'd0, 1'b1, s[0], ~s[1]});
    end
    bus_write(A_OCTL + 16'd5, 8'h06);
    chk("R4 pull disabled", {29'd0, pad_pull_en[5], pad_pull_up[5], pad_pull_strong[5]}, 0);
    bus_write(A_OCTL + 16'd5, 8'h00);

    // R5 level latency on pin 9
    @(negedge clk);
    pad_in[9] = 1'b1; bus_addr = A_ICTL + 16'd9; bus_re = 1'b1;
    @(negedge clk); chk("R5 level after one edge", {31'd0, bus_rdata[0]}, 0);
    @(negedge clk); chk("R5 level after two edges", {31'd0, bus_rdata[0]}, 0);
    @(negedge clk); chk("R5 level after three edges", {31'd0, bus_rdata[0]}, 1);
    bus_re = 1'b0;
    bus_write(A_ICTL + 16'd9, 8'h00);
    bus_read(A_ICTL + 16'd9, d);       chk("R5 bit0 write ignored", {24'd0, d}, 32'h01);
    set_pad(9, 1'b0);

    // R11 read data hold
    bus_read(A_OCTL, d);
    bus_write(A_OCTL, 8'h3f);
    chk("R11 rdata held", {24'd0, bus_rdata}, 0);
    bus_write(A_OCTL, 8'h00);

    // R6 edge selection on pin 3, with R8 clears between
    for (int m = 0; m < 4; m++) begin
      bus_write(A_ICTL + 16'd3, 8'(m << 1));
      set_pad(3, 1'b1);
      bus_read(A_STAT, d);
      chk("R6 rising", {31'd0, d[3]}, {31'd0, (m == 2 || m == 3)});
      bus_write(A_STAT, 8'h7f);
      set_pad(3, 1'b0);
      bus_read(A_STAT, d);
      chk("R6 falling", {31'd0, d[3]}, {31'd0, (m == 1 || m == 3)});
      bus_write(A_STAT, 8'h7f);
    end
    bus_write(A_ICTL + 16'd3, 8'h00);

    // R7 grouping: pin 11 lands in high group bit 4
    bus_write(A_ICTL + 16'd11, 8'h06);
    set_pad(11, 1'b1);
    bus_read(A_STAT, d);               chk("R7 low group clear", {24'd0, d}, 0);
    bus_read(A_STAT + 16'd1, d);       chk("R7 high group bit", {24'd0, d}, 32'h10);

    // R9 masked event recorded, irq only when unmasked
    chk("R9 masked irq", {31'd0, irq}, 0);
    bus_write(A_MASK + 16'd1, 8'h2f);
    chk("R9 unmasked irq", {31'd0, irq}, 1);
    // R8 writing zero keeps the bit
    bus_write(A_STAT + 16'd1, 8'h00);
    bus_read(A_STAT + 16'd1, d);       chk("R8 zero write keeps", {24'd0, d}, 32'h10);
    bus_write(A_STAT + 16'd1, 8'h10);
    chk("R8 clear drops irq", {31'd0, irq}, 0);

    // R10 event and clear in the same cycle: pin change, two edges, then write on third
    set_pad(11, 1'b0);
    @(negedge clk); pad_in[11] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_STAT + 16'd1; bus_wdata = 8'h10; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    bus_read(A_STAT + 16'd1, d);       chk("R10 event wins", {24'd0, d}, 32'h10);
    chk("R10 irq held", {31'd0, irq}, 1);

    // Random phase
    bus_write(A_STAT + 16'd1, 8'h3f);
    bus_write(A_STAT, 8'h7f);
    st_m = '0; lvl_m = pad_in;
    mk_m = {6'h2f, 7'h7f};
    for (int p = 0; p < N; p++) begin
      mode_m[p] = 2'($urandom);
      bus_write(A_ICTL + 16'(p), {5'd0, mode_m[p], 1'b0});
    end
    for (int it = 0; it < 80; it++) begin
      int act;
      act = int'($urandom % 4);
      if (act < 2) begin
        int p;
        logic nv;
        p = int'($urandom % N);
        nv = ~lvl_m[p];
        if (hit_m(mode_m[p], lvl_m[p], nv)) st_m[p] = 1'b1;
        lvl_m[p] = nv;
        set_pad(p, nv);
      end else if (act == 2) begin
        logic [7:0] w;
        logic g;
        w = 8'($urandom); g = 1'($urandom);
        bus_write(A_STAT + 16'(g), w);
        if (g) st_m[12:7] = st_m[12:7] & ~w[5:0];
        else   st_m[6:0]  = st_m[6:0] & ~w[6:0];
      end else begin
        logic [7:0] w;
        logic g;
        w = 8'($urandom); g = 1'($urandom);
        bus_write(A_MASK + 16'(g), w);
        if (g) mk_m[12:7] = w[5:0];
        else   mk_m[6:0]  = w[6:0];
      end
      check_status("R6 R8 R9 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule